// File: doc/BRIEF.md
# Sigma-Delta Calibration Sequencer

This controller performs one offset or one gain calibration measurement on the single-bit output of a sigma-delta modulator. It runs on the modulator master clock. When a run is requested, it selects the calibration input, either zero-input or gain, and drives it for the whole measurement. It first holds the modulator in reset, then waits a fixed settling interval. After that it counts the ones in a window of stream bits whose length is a power of two.

Stream bits arrive with their own serial clock. They are synchronised into the master-clock domain and taken on each rising serial-clock edge. At the end of a run the block holds the raw ones count and a signed deviation from the ideal count. The ideal count depends on the calibration type and on the polarity mode that was captured when the run started. The result is flagged valid only while the polarity mode input still equals that captured mode.

Top module: `cal_seq`

## Requirements
- R1: After reset, mod_zero, mod_gain, mod_reset, busy, done and result_valid are all 0 and ones_count is 0.
- R2: A start seen in idle makes mod_reset 1 from the next cycle for exactly RST_CYCLES cycles.
- R3: From the cycle after an accepted start until done, exactly one calibration control is 1. mod_gain is 1 when cal_gain was 1 at start, and mod_zero is 1 when it was 0. The two controls are never 1 together, and both are 0 in idle.
- R4: No stream bit is counted before SETTLE_CYCLES cycles have passed after the reset phase. The time from start to done is therefore at least RST_CYCLES + SETTLE_CYCLES plus one window of serial-clock periods.
- R5: Stream bits are sampled on rising sclk edges. ones_count equals the number of 1 bits among 2^WIN_LOG2 consecutive stream bits, and never exceeds 2^WIN_LOG2.
- R6: deviation = ones_count − ideal, as a signed value. With W = 2^WIN_LOG2, ideal is 5W/8 for a gain run, W/2 for a zero-input run in bipolar mode (bipolar=1), and 3W/8 for a zero-input run in unipolar mode (bipolar=0).
- R7: result_valid rises together with done. It goes to 0 one cycle after bipolar differs from the mode captured at start, and it stays 0 until a new run completes. It is also 0 from the cycle after a new start is accepted.
- R8: A start asserted while busy has no effect: the reset phase does not restart and the selected control does not change.
- R9: The run steps through idle, reset, settle, count and done, in that order. done is a one-cycle pulse and busy is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a calibration run (taken only in idle) |
| cal_gain | input | 1 | Run type: 1 gain, 0 zero-input |
| bipolar | input | 1 | Polarity mode: 1 bipolar, 0 unipolar |
| sclk | input | 1 | Serial clock of the stream |
| sdata | input | 1 | Modulator bit stream |
| mod_zero | output | 1 | Zero-input calibration control |
| mod_gain | output | 1 | Gain calibration control |
| mod_reset | output | 1 | Modulator reset |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result_valid | output | 1 | Stored result matches current mode |
| ones_count | output | WIN_LOG2+1 | Ones counted in the window |
| deviation | output | WIN_LOG2+2 | Signed ones_count minus ideal |

## Verification
The bench drives stream patterns with a period of eight bits. Every window therefore holds a known number of ones, including the all-zero and all-one extremes. A counter that is one bit too narrow wraps to 0 at the all-one pattern. A wrong ideal count for one of the three targets gives a visibly wrong deviation. Each run also times the reset phase and the start-to-done latency, which exposes early counting during settle. Further checks pulse start while busy, which a restartable sequencer would act on, and toggle the mode after a result, where a sticky valid flag would stay high.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RESET  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_COUNT  = 3'd3,
        ST_DONE   = 3'd4
    } cal_state_e;
endpackage

// File: rtl/cal_bit_sampler.sv
module cal_bit_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdata,
    output logic bit_stb,
    output logic bit_val
);
    logic [SYNC_STAGES-1:0] ck_d, ck_q, dt_d, dt_q;
    logic                   last_d, last_q;

    always_comb begin
        ck_d[0] = sclk;
        dt_d[0] = sdata;
        last_d  = ck_q[SYNC_STAGES-1];
    end

    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
        always_comb begin
            ck_d[i] = ck_q[i-1];
            dt_d[i] = dt_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_q   <= '0;
            dt_q   <= '0;
            last_q <= 1'b0;
        end else begin
            ck_q   <= ck_d;
            dt_q   <= dt_d;
            last_q <= last_d;
        end
    end

    assign bit_stb = ck_q[SYNC_STAGES-1] & ~last_q;
    assign bit_val = dt_q[SYNC_STAGES-1];

    // R5
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
endmodule

// File: rtl/cal_dev_calc.sv
module cal_dev_calc #(
    parameter int WIN_LOG2 = 8
) (
    input  logic [WIN_LOG2:0]          count,
    input  logic                       bipolar,
    input  logic                       gain_step,
    output logic signed [WIN_LOG2+1:0] deviation
);
    localparam int WIN    = 1 << WIN_LOG2;
    localparam int CW     = WIN_LOG2 + 1;
    localparam int DW     = WIN_LOG2 + 2;
    localparam logic [CW-1:0] HALF   = CW'(WIN >> 1);
    localparam logic [CW-1:0] EIGHTH = CW'(WIN >> 3);

    logic [CW-1:0] ideal;

    always_comb begin
        if (gain_step)    ideal = HALF + EIGHTH;
        else if (bipolar) ideal = HALF;
        else              ideal = HALF - EIGHTH;
        deviation = $signed(DW'(count) - DW'(ideal));
    end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_seq_pkg::*;
#(
    parameter int WIN_LOG2      = 8,
    parameter int SETTLE_CYCLES = 1000,
    parameter int RST_CYCLES    = 20,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       cal_gain,
    input  logic                       bipolar,
    input  logic                       sclk,
    input  logic                       sdata,
    output logic                       mod_zero,
    output logic                       mod_gain,
    output logic                       mod_reset,
    output logic                       busy,
    output logic                       done,
    output logic                       result_valid,
    output logic [WIN_LOG2:0]          ones_count,
    output logic signed [WIN_LOG2+1:0] deviation
);
    localparam int WIN  = 1 << WIN_LOG2;
    localparam int CW   = WIN_LOG2 + 1;
    localparam int TMAX = (SETTLE_CYCLES > RST_CYCLES) ? SETTLE_CYCLES : RST_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        cal_state_e    state;
        logic [TW-1:0] tmr;
        logic [CW-1:0] bits;
        logic [CW-1:0] count;
        logic          gain;
        logic          mode;
        logic          valid;
    } seq_t;

    seq_t q, n;
    logic bit_stb, bit_val;

    cal_bit_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
        .bit_stb(bit_stb), .bit_val(bit_val)
    );

    cal_dev_calc #(.WIN_LOG2(WIN_LOG2)) u_dev (
        .count(q.count), .bipolar(q.mode), .gain_step(q.gain),
        .deviation(deviation)
    );

    always_comb begin
        n = q;
        case (q.state)
            ST_IDLE: if (start) begin
                n.state = ST_RESET;
                n.tmr   = '0;
                n.bits  = '0;
                n.count = '0;
                n.gain  = cal_gain;
                n.mode  = bipolar;
                n.valid = 1'b0;
            end
            ST_RESET: begin
                if (q.tmr == TW'(RST_CYCLES - 1)) begin
                    n.state = ST_SETTLE;
                    n.tmr   = '0;
                end else n.tmr = q.tmr + 1'b1;
            end
            ST_SETTLE: begin
                if (q.tmr == TW'(SETTLE_CYCLES - 1)) begin
                    n.state = ST_COUNT;
                    n.tmr   = '0;
                end else n.tmr = q.tmr + 1'b1;
            end
            ST_COUNT: if (bit_stb) begin
                n.bits  = q.bits + 1'b1;
                n.count = q.count + CW'(bit_val);
                if (q.bits == CW'(WIN - 1)) begin
                    n.state = ST_DONE;
                    n.valid = 1'b1;
                end
            end
            ST_DONE: n.state = ST_IDLE;
            default: n.state = ST_IDLE;
        endcase
        if (bipolar != q.mode) n.valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    logic active;
    assign active       = (q.state == ST_RESET) || (q.state == ST_SETTLE) || (q.state == ST_COUNT);
    assign mod_zero     = active && !q.gain;
    assign mod_gain     = active &&  q.gain;
    assign mod_reset    = (q.state == ST_RESET);
    assign busy         = (q.state != ST_IDLE);
    assign done         = (q.state == ST_DONE);
    assign result_valid = q.valid;
    assign ones_count   = q.count;

    // R3
    ctl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mod_zero && mod_gain));
    // R2
    rst_with_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_reset) |-> (mod_zero || mod_gain));
    // R4
    count_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SETTLE) |=> (q.count == '0));
    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_count <= CW'(WIN));
    // R7
    mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bipolar != q.mode) |=> !result_valid);
    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$rose(mod_reset));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: tb/cal_seq_tb.sv
module cal_seq_tb;
    localparam int WIN_LOG2 = 8;
    localparam int WIN      = 1 << WIN_LOG2;
    localparam int SETTLE   = 1000;
    localparam int RSTC     = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, cal_gain = 1'b0, bipolar = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0;
    logic mod_zero, mod_gain, mod_reset, busy, done, result_valid;
    logic [WIN_LOG2:0] ones_count;
    logic signed [WIN_LOG2+1:0] deviation;

    int total = 0;
    int bad   = 0;
    int cyc_all = 0;
    logic [7:0] mask = 8'h00;
    logic [1:0] div = 2'd0;
    logic [2:0] idx = 3'd0;

    cal_seq #(.WIN_LOG2(WIN_LOG2), .SETTLE_CYCLES(SETTLE), .RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_gain(cal_gain), .bipolar(bipolar),
        .sclk(sclk), .sdata(sdata), .mod_zero(mod_zero), .mod_gain(mod_gain),
        .mod_reset(mod_reset), .busy(busy), .done(done), .result_valid(result_valid),
        .ones_count(ones_count), .deviation(deviation)
    );

    always #2 clk = ~clk;

    // stream source: period 4 clocks, data changes on sclk fall
    always @(negedge clk) begin
        div = div + 2'd1;
        if (div == 2'd0) begin
            idx = idx + 3'd1;
            sdata = mask[idx];
        end
        sclk = div[1];
    end

    always @(posedge clk) begin
        cyc_all = cyc_all + 1;
        if (cyc_all > 190000) begin
            $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc_all);
            bad = bad + 1;
            total = total + 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pop8(input logic [7:0] m);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic int ideal_of(input bit g, input bit bp);
        if (g) return WIN / 2 + WIN / 8;
        if (bp) return WIN / 2;
        return WIN / 2 - WIN / 8;
    endfunction

    task automatic run(input bit g, input bit bp, input logic [7:0] m, input bit poke);
        int cyc = 0;
        int rst_len = 0;
        bit ctl_ok = 1'b1;
        int exp_cnt;
        int exp_dev;
        @(negedge clk);
        mask = m;
        cal_gain = g;
        bipolar = bp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        check(mod_reset == 1'b1, "R2 reset on start", int'(mod_reset), 1);
        check(result_valid == 1'b0, "R7 valid cleared on start", int'(result_valid), 0);
        while (!done && cyc < 5000) begin
            if (mod_reset) rst_len++;
            if (mod_gain != g || mod_zero != !g) ctl_ok = 1'b0;
            if (poke && cyc == 100) begin
                start = 1'b1;
                cal_gain = !g;
            end
            if (poke && cyc == 101) begin
                start = 1'b0;
            end
            if (poke && cyc == 103) begin
                check(mod_reset == 1'b0 && mod_gain == g, "R8 start ignored while busy",
                      int'(mod_reset), 0);
            end
            @(negedge clk);
            cyc++;
        end
        check(rst_len == RSTC, "R2 reset length", rst_len, RSTC);
        check(ctl_ok, "R3 control held and exclusive", int'(ctl_ok), 1);
        check(cyc >= RSTC + SETTLE + (WIN - 1) * 4 && cyc <= RSTC + SETTLE + (WIN + 1) * 4 + 2,
              "R4 start-to-done latency", cyc, RSTC + SETTLE + WIN * 4);
        exp_cnt = pop8(m) * (WIN / 8);
        exp_dev = exp_cnt - ideal_of(g, bp);
        check(int'(ones_count) == exp_cnt, "R5 ones count", int'(ones_count), exp_cnt);
        check(int'(deviation) == exp_dev, "R6 deviation", int'(deviation), exp_dev);
        check(result_valid == 1'b1, "R7 valid at done", int'(result_valid), 1);
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9 done single pulse then idle", int'(busy), 0);
        check(mod_zero == 1'b0 && mod_gain == 1'b0, "R3 controls low in idle",
              int'(mod_zero) + int'(mod_gain), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mod_zero && !mod_gain && !mod_reset, "R1 controls in reset",
              int'(mod_zero) + int'(mod_gain) + int'(mod_reset), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !result_valid && ones_count == 0, "R1 status after reset",
              int'(busy) + int'(done) + int'(result_valid) + int'(ones_count), 0);

        // directed corners
        run(1'b0, 1'b1, 8'h00, 1'b0);
        run(1'b1, 1'b0, 8'hFF, 1'b0);
        run(1'b0, 1'b0, 8'h55, 1'b1);

        // R7 mode change invalidates, and toggling back does not restore
        bipolar = !bipolar;
        @(negedge clk); @(negedge clk);
        check(result_valid == 1'b0, "R7 mode change drops valid", int'(result_valid), 0);
        bipolar = !bipolar;
        @(negedge clk); @(negedge clk);
        check(result_valid == 1'b0, "R7 valid stays low after mode restored", int'(result_valid), 0);

        // random runs
        for (int k = 0; k < 10; k++) begin
            logic [31:0] r = $urandom;
            run(r[0], r[1], r[15:8], r[2]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule